// File: doc/BRIEF.md
# Synchronized Flash Pulse Generator

This block makes blinking output levels for eight output channels. A slow flash clock comes from outside and is not related to the system clock. It passes through a two-stage synchronizer on the system clock. An edge detector then turns each of its rising edges into a single-cycle tick.

Each group of four channels has its own 2-bit ratio code and its own tick divider. The divider produces a square-wave flash phase whose period is 1, 2, 4 or 16 flash-clock periods. For a channel with pulsing enabled, the phase masks that channel's data bit. A channel with pulsing disabled passes its data bit straight through. The system clock must be much faster than the flash clock, for example 2 MHz against 50 Hz.

Top module: `flash_blink_gen`

## Requirements
- R1: While rst_ni is low, both divider counters clear and both registered flash phases are forced high. After release with a ratio code other than 00, every enabled channel shows its data bit.
- R2: A channel whose bit in pulse_en_i is 0 drives data_i of that bit on out_o, whatever the flash phase.
- R3: A channel whose bit in pulse_en_i is 1 drives data_i AND the flash phase of its nibble.
- R4: Ratio code 00 selects a ratio of 1: the nibble's phase equals the synchronized flash clock level.
- R5: Ratio code 01 selects a ratio of 2: the phase toggles on every rising edge of the flash clock.
- R6: Ratio code 10 selects a ratio of 4: the phase toggles on every second rising edge.
- R7: Ratio code 11 selects a ratio of 16: the phase toggles on every eighth rising edge, and the counter never exceeds 7.
- R8: Channels 3:0 use ratio_lo_i and channels 7:4 use ratio_hi_i, and the two dividers run independently.
- R9: A rising edge on flash_clk_i that is set up before a system clock edge behaves as follows. It reaches a ratio-00 phase on the second system clock edge after it. It toggles a registered phase on the third.
- R10: A flash clock held high gives one tick only: no further toggles follow until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flash_clk_i | input | 1 | Slow flash clock, asynchronous |
| ratio_lo_i | input | 2 | Ratio code for channels 3:0 (00=1, 01=2, 10=4, 11=16) |
| ratio_hi_i | input | 2 | Ratio code for channels 7:4 (same encoding) |
| data_i | input | 8 | Output data per channel |
| pulse_en_i | input | 8 | Pulse enable per channel |
| out_o | output | 8 | Gated output level per channel |

## Verification
The data and enable paths are combinational, so a change in data_i or pulse_en_i shows on out_o in the same cycle. A rising flash-clock edge reaches a ratio-00 nibble two system clock edges later and a divided nibble three edges later. A falling edge reaches only ratio-00 nibbles, also two edges later. The bench drives all inputs on the falling system clock edge. For plateau checks it queues the expected value six cycles after each flash-clock transition, when every register on the path has settled. For R9 it queues a value after each of the first three edges. The monitor compares each queued value shortly after the falling edge at which it was pushed, before the next rising edge can move any register.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [1:0] {
    RATIO_1  = 2'b00,
    RATIO_2  = 2'b01,
    RATIO_4  = 2'b10,
    RATIO_16 = 2'b11
  } ratio_code_e;

  localparam int unsigned CNT_W    = 4;
  localparam int unsigned MAX_HALF = 8;

  // ticks per half period, minus one
  function automatic logic [CNT_W-1:0] half_minus_one(ratio_code_e code);
    case (code)
      RATIO_2:  return CNT_W'(0);
      RATIO_4:  return CNT_W'(1);
      RATIO_16: return CNT_W'(MAX_HALF - 1);
      default:  return CNT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/flash_sync_edge.sv
module flash_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o,
  output logic tick_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
      prev_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign sync_o = chain_q[SYNC_STAGES-1];
  assign tick_o = sync_o & ~prev_q;

  p_single_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/flash_divider.sv
module flash_divider
  import flash_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        sync_i,
  input  ratio_code_e code_i,
  output logic        phase_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic [CNT_W-1:0] limit;

  assign limit = half_minus_one(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (code_i == RATIO_1) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= limit) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // ratio 1 bypasses the register
  assign phase_o = (code_i == RATIO_1) ? sync_i : phase_q;

  p_ratio2_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == RATIO_2 && tick_i) |=> (phase_q != $past(phase_q)));

  p_hold_without_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q));

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_HALF));

endmodule

// File: rtl/flash_gate.sv
module flash_gate #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic             phase_i,
  output logic [WIDTH-1:0] out_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_ch
    assign out_o[b] = en_i[b] ? (data_i[b] & phase_i) : data_i[b];
  end

endmodule

// File: rtl/flash_blink_gen.sv
module flash_blink_gen
  import flash_pkg::*;
#(
  parameter int unsigned CH_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flash_clk_i,
  input  logic [1:0]      ratio_lo_i,
  input  logic [1:0]      ratio_hi_i,
  input  logic [CH_W-1:0] data_i,
  input  logic [CH_W-1:0] pulse_en_i,
  output logic [CH_W-1:0] out_o
);

  localparam int unsigned NUM_NIB = 2;
  localparam int unsigned NIB_W   = CH_W / NUM_NIB;

  logic            flash_sync;
  logic            flash_tick;
  ratio_code_e     code   [NUM_NIB];
  logic [NUM_NIB-1:0] phase;
  logic [CH_W-1:0] phase_vec;

  assign code[0] = ratio_code_e'(ratio_lo_i);
  assign code[1] = ratio_code_e'(ratio_hi_i);

  flash_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (flash_clk_i),
    .sync_o  (flash_sync),
    .tick_o  (flash_tick)
  );

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    flash_divider u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (flash_tick),
      .sync_i  (flash_sync),
      .code_i  (code[n]),
      .phase_o (phase[n])
    );

    flash_gate #(.WIDTH(NIB_W)) u_gate (
      .data_i  (data_i[n*NIB_W +: NIB_W]),
      .en_i    (pulse_en_i[n*NIB_W +: NIB_W]),
      .phase_i (phase[n]),
      .out_o   (out_o[n*NIB_W +: NIB_W])
    );

    assign phase_vec[n*NIB_W +: NIB_W] = {NIB_W{phase[n]}};
  end

  p_dark_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pulse_en_i & ~phase_vec & out_o) == '0));

  p_pass_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pulse_en_i & (out_o ^ data_i)) == '0));

endmodule

// File: tb/flash_blink_gen_tb.sv
module flash_blink_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flash = 1'b0;
  logic [1:0] r_lo = 2'b00, r_hi = 2'b00;
  logic [7:0] dat = 8'h00, en = 8'h00;
  logic [7:0] out;

  int n_chk = 0, n_fail = 0;
  int k = 0;
  bit done = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_blink_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flash_clk_i(flash),
    .ratio_lo_i(r_lo), .ratio_hi_i(r_hi),
    .data_i(dat), .pulse_en_i(en), .out_o(out)
  );

  function automatic logic phase_of(logic [1:0] code);
    int half;
    case (code)
      2'b01: half = 1;
      2'b10: half = 2;
      2'b11: half = 8;
      default: half = 0;
    endcase
    if (half == 0) return flash;
    return ((k / half) % 2) == 0;
  endfunction

  function automatic logic [7:0] model();
    logic [7:0] e;
    logic ph;
    for (int i = 0; i < 8; i++) begin
      ph = phase_of(i < 4 ? r_lo : r_hi);
      e[i] = en[i] ? (dat[i] & ph) : dat[i];
    end
    return e;
  endfunction

  task automatic push(logic [7:0] e, string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (out !== it.exp) begin
          n_fail++;
          $display("FAIL %s: out=%h expected=%h", it.tag, out, it.exp);
        end
      end
    end
  end

  task automatic do_reset(logic [1:0] lo, logic [1:0] hi);
    @(negedge clk);
    rst_n = 1'b0;
    flash = 1'b0;
    r_lo = lo;
    r_hi = hi;
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic flash_pulses(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      flash = 1'b1;
      k++;
      repeat (6) @(negedge clk);
      push(model(), tag);
      repeat (2) @(negedge clk);
      flash = 1'b0;
      repeat (6) @(negedge clk);
      push(model(), tag);
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    // R1 reset state, ratios 2 and 16
    dat = 8'hFF;
    en  = 8'hFF;
    do_reset(2'b01, 2'b11);
    @(negedge clk);
    push(8'hFF, "R1 reset phase high");
    // R5 R7 R8 R3
    flash_pulses(9, "R5 R7 R8 R3 ratio 2/16");
    dat = 8'h5A;
    flash_pulses(9, "R3 R7 data 5A");
    // R2 mixed enables
    en  = 8'h0F;
    dat = 8'hA5;
    flash_pulses(4, "R2 disabled channels pass");
    en  = 8'h00;
    dat = 8'h3C;
    flash_pulses(2, "R2 all disabled");

    // R4 R6
    dat = 8'hFF;
    en  = 8'hFF;
    do_reset(2'b00, 2'b10);
    @(negedge clk);
    push(8'hF0, "R1 R4 ratio1 low after reset");
    flash_pulses(6, "R4 R6 ratio 1/4");
    en = 8'h3C;
    dat = 8'hE7;
    flash_pulses(4, "R4 R6 R8 mixed");

    // R9 latency: lo ratio 1, hi ratio 2
    dat = 8'hFF;
    en  = 8'hFF;
    do_reset(2'b00, 2'b01);
    @(negedge clk);
    flash = 1'b1;
    @(negedge clk);
    push(8'hF0, "R9 one edge: no change");
    @(negedge clk);
    push(8'hFF, "R9 two edges: ratio1 follows");
    @(negedge clk);
    push(8'h0F, "R9 three edges: ratio2 toggles");
    // R10 hold high
    repeat (40) @(negedge clk);
    push(8'h0F, "R10 held high no retoggle");
    repeat (40) @(negedge clk);
    push(8'h0F, "R10 held high long");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: out=%h expected=finish", out);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule